// File: doc/BRIEF.md
# Programmable Parity Encoder Shift Register

This block is a configurable shift register for producing cyclic parity or CRC check bits. It is built in the Galois form: an XOR gate can sit in front of each register bit, and each gate takes the value coming from the bit to its left. Two separate tap registers decide what else feeds each gate. One ties the gate to the feedback line and the other ties it to the serial input. A one-hot degree mask picks the register bit that drives the feedback line, and that choice also sets the degree of the generator polynomial. A select register picks the subset of bits that a zero-detect flag watches.

Software programs the tap, mask and select registers through a small write/read port. It then presents message bits on the serial input and raises the step enable once per bit. After the message it clears the input enable, so that further steps are driven only by feedback. The bits found in the register are the check bits. On the receive side, the zero-detect flag over the chosen bits reports whether the remainder is clean. The shift register can be loaded or cleared from software, or cleared by a local clear pin without losing the configuration.

Top module: `parity_enc_sreg`

## Requirements
- R1: After synchronous reset every register reads 0, `zero_flag` is 1 and `fb_out` is 0 for any serial input.
- R2: A write to address 0 (state), 1 (feedback taps), 2 (input taps), 3 (degree mask) or 4 (zero-detect select) is returned on `rd_data` one cycle after that address is presented. Addresses 5 to 7 read as 0.
- R3: On a step with `u = din & din_en` and feedback line `f`, bit 0 becomes `(fbt[0]&f)^(fft[0]&u)`, and each bit i>0 becomes `s[i-1]^(fbt[i]&f)^(fft[i]&u)`. Bit 0 is the leftmost bit, and data moves toward higher indices.
- R4: Without a step, a load or a clear, the state register keeps its value.
- R5: With a one-hot mask at bit d, `fb_out = s[d] ^ (din & din_en)`, so clearing `din_en` removes the input from the feedback.
- R6: If the mask has several bits set, the lowest set bit acts as d. An all-zero mask makes `fb_out` 0.
- R7: `zero_flag` is 1 exactly when every state bit marked in the select register is 0. An empty selection gives 1.
- R8: `loc_clr` clears the state register on the next edge and leaves all configuration registers unchanged.
- R9: A write to the state address in the same cycle as a step loads the written value, and the step is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of all registers |
| loc_clr | input | 1 | Clears the state register only |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for write and read |
| wr_data | input | W | Write data |
| rd_data | output | W | Registered read data |
| din | input | 1 | Serial message bit |
| din_en | input | 1 | Input enable; low gates the input to zero |
| step | input | 1 | Advance the register by one bit |
| fb_out | output | 1 | Current feedback line |
| zero_flag | output | 1 | High when all selected state bits are zero |

## Verification
On every cycle, the assertions check several properties: the state holds when nothing acts on it, loads and clears take effect on the next edge, unused addresses read back zero, the flag agrees with the selected state bits, and the feedback line obeys the gating and the empty-mask rule. Only the bench scenarios can show that the per-bit update equation is right under random tap, mask and input patterns, that the lowest-set-bit rule holds for every mask position, and that a known generator polynomial produces its textbook remainder.

// File: rtl/pe_pkg.sv
package pe_pkg;
  localparam int AW = 3;
  localparam logic [AW-1:0] A_STATE = 3'd0;
  localparam logic [AW-1:0] A_FBT   = 3'd1;
  localparam logic [AW-1:0] A_FFT   = 3'd2;
  localparam logic [AW-1:0] A_MASK  = 3'd3;
  localparam logic [AW-1:0] A_SEL   = 3'd4;
endpackage

// File: rtl/pe_cfg_regs.sv
module pe_cfg_regs #(
  parameter int W = 24
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [pe_pkg::AW-1:0]   addr,
  input  logic [W-1:0]            wr_data,
  output logic [W-1:0]            fbt,
  output logic [W-1:0]            fft,
  output logic [W-1:0]            mask,
  output logic [W-1:0]            sel
);
  import pe_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      fbt  <= '0;
      fft  <= '0;
      mask <= '0;
      sel  <= '0;
    end else if (wr_en) begin
      case (addr)
        A_FBT:   fbt  <= wr_data;
        A_FFT:   fft  <= wr_data;
        A_MASK:  mask <= wr_data;
        A_SEL:   sel  <= wr_data;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pe_feedback.sv
module pe_feedback #(
  parameter int W = 24
) (
  input  logic [W-1:0] state,
  input  logic [W-1:0] mask,
  input  logic         u,
  output logic         fb
);
  logic [W-1:0] low_bit;
  logic         src;

  // isolate the lowest set mask bit
  assign low_bit = mask & (~mask + {{(W-1){1'b0}}, 1'b1});
  assign src     = |(state & low_bit);
  assign fb      = (|mask) ? (src ^ u) : 1'b0;
endmodule

// File: rtl/pe_zero_det.sv
module pe_zero_det #(
  parameter int W = 24
) (
  input  logic [W-1:0] state,
  input  logic [W-1:0] sel,
  output logic         is_zero
);
  assign is_zero = ~|(state & sel);
endmodule

// File: rtl/pe_shift_core.sv
module pe_shift_core #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] ld_data,
  input  logic         step,
  input  logic         f,
  input  logic         u,
  input  logic [W-1:0] fbt,
  input  logic [W-1:0] fft,
  output logic [W-1:0] state
);
  logic [W-1:0] nxt;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0) begin : g_first
      assign nxt[i] = (fbt[i] & f) ^ (fft[i] & u);
    end else begin : g_rest
      assign nxt[i] = state[i-1] ^ (fbt[i] & f) ^ (fft[i] & u);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) state <= '0;
    else if (ld)    state <= ld_data;
    else if (step)  state <= nxt;
  end
endmodule

// File: rtl/parity_enc_sreg.sv
module parity_enc_sreg #(
  parameter int W = 24
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  loc_clr,
  input  logic                  wr_en,
  input  logic [pe_pkg::AW-1:0] addr,
  input  logic [W-1:0]          wr_data,
  output logic [W-1:0]          rd_data,
  input  logic                  din,
  input  logic                  din_en,
  input  logic                  step,
  output logic                  fb_out,
  output logic                  zero_flag
);
  import pe_pkg::*;

  logic [W-1:0] state_q, fbt_q, fft_q, mask_q, sel_q;
  logic         u_in;
  logic         ld_state;
  logic [W-1:0] rd_mux;

  assign u_in     = din & din_en;
  assign ld_state = wr_en && (addr == A_STATE);

  pe_cfg_regs #(.W(W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .fbt(fbt_q), .fft(fft_q), .mask(mask_q), .sel(sel_q)
  );

  pe_feedback #(.W(W)) u_fb (
    .state(state_q), .mask(mask_q), .u(u_in), .fb(fb_out)
  );

  pe_shift_core #(.W(W)) u_core (
    .clk(clk), .rst(rst), .clr(loc_clr), .ld(ld_state), .ld_data(wr_data),
    .step(step), .f(fb_out), .u(u_in), .fbt(fbt_q), .fft(fft_q),
    .state(state_q)
  );

  pe_zero_det #(.W(W)) u_zd (
    .state(state_q), .sel(sel_q), .is_zero(zero_flag)
  );

  always_comb begin
    case (addr)
      A_STATE: rd_mux = state_q;
      A_FBT:   rd_mux = fbt_q;
      A_FFT:   rd_mux = fft_q;
      A_MASK:  rd_mux = mask_q;
      A_SEL:   rd_mux = sel_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end
endmodule

// File: rtl/pe_checker.sv
module pe_checker #(
  parameter int W = 24
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  loc_clr,
  input logic                  wr_en,
  input logic [pe_pkg::AW-1:0] addr,
  input logic [W-1:0]          wr_data,
  input logic [W-1:0]          rd_data,
  input logic                  din,
  input logic                  din_en,
  input logic                  step,
  input logic                  fb_out,
  input logic                  zero_flag,
  input logic [W-1:0]          state_q,
  input logic [W-1:0]          mask_q,
  input logic [W-1:0]          sel_q
);
  AST_HOLD_STATE: assert property (@(posedge clk) disable iff (rst)
    (!step && !loc_clr && !(wr_en && addr == pe_pkg::A_STATE)) |=> $stable(state_q)); // R4
  AST_LOCAL_CLEAR: assert property (@(posedge clk) disable iff (rst)
    loc_clr |=> (state_q == '0)); // R8
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == pe_pkg::A_STATE && !loc_clr) |=> (state_q == $past(wr_data))); // R9
  AST_UNUSED_ADDR: assert property (@(posedge clk) disable iff (rst)
    (addr > pe_pkg::A_SEL) |=> (rd_data == '0)); // R2
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
    zero_flag == ((state_q & sel_q) == '0)); // R7
  AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |-> !fb_out); // R6
  AST_GATED_FB: assert property (@(posedge clk) disable iff (rst)
    ($onehot0(mask_q) && mask_q != '0 && !din_en) |-> (fb_out == |(state_q & mask_q))); // R5
endmodule

bind parity_enc_sreg pe_checker #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .loc_clr(loc_clr), .wr_en(wr_en), .addr(addr),
  .wr_data(wr_data), .rd_data(rd_data), .din(din), .din_en(din_en),
  .step(step), .fb_out(fb_out), .zero_flag(zero_flag),
  .state_q(state_q), .mask_q(mask_q), .sel_q(sel_q)
);

// File: tb/sim_parity_enc_sreg.sv
`timescale 1ns/1ps
module sim_parity_enc_sreg;
  localparam int W = 24;
  logic clk = 0, rst = 1, loc_clr = 0, wr_en = 0, din = 0, din_en = 0, step = 0;
  logic [2:0] addr = '0;
  logic [W-1:0] wr_data = '0, rd_data;
  logic fb_out, zero_flag;
  int n_chk = 0, n_fail = 0;
  logic [31:0] rng = 32'h1234_5679;

  always #10 clk = ~clk;

  parity_enc_sreg #(.W(W)) u0 (
    .clk(clk), .rst(rst), .loc_clr(loc_clr), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .din(din), .din_en(din_en),
    .step(step), .fb_out(fb_out), .zero_flag(zero_flag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nextrand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return rng;
  endfunction

  function automatic logic m_fb(logic [W-1:0] s, logic [W-1:0] m, logic u);
    for (int i = 0; i < W; i++) if (m[i]) return s[i] ^ u;
    return 1'b0;
  endfunction

  function automatic logic [W-1:0] m_step(logic [W-1:0] s, logic [W-1:0] fb_t,
      logic [W-1:0] ff_t, logic [W-1:0] m, logic u);
    logic [W-1:0] n;
    logic f;
    f = m_fb(s, m, u);
    for (int i = 0; i < W; i++)
      n[i] = (i == 0 ? 1'b0 : s[i-1]) ^ (fb_t[i] & f) ^ (ff_t[i] & u);
    return n;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  logic [W-1:0] rv;

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), rv);
      check("R1 reset read", 32'(rv), 32'h0);
    end
    din = 1; din_en = 1; #1;
    check("R1 zero_flag", 32'(zero_flag), 32'h1);
    check("R1 fb_out", 32'(fb_out), 32'h0);
    din = 0; din_en = 0;

    // R2 write/readback and unused addresses
    wr(3'd0, 24'h123456); wr(3'd1, 24'hABCDEF); wr(3'd2, 24'h0F0F0F);
    wr(3'd3, 24'h000100); wr(3'd4, 24'hF00001);
    begin
      logic [W-1:0] expv [5];
      expv[0] = 24'h123456; expv[1] = 24'hABCDEF; expv[2] = 24'h0F0F0F;
      expv[3] = 24'h000100; expv[4] = 24'hF00001;
      for (int a = 0; a < 5; a++) begin
        rd(3'(a), rv);
        check("R2 readback", 32'(rv), 32'(expv[a]));
      end
    end
    for (int a = 5; a < 8; a++) begin
      rd(3'(a), rv);
      check("R2 unused address", 32'(rv), 32'h0);
    end

    // R3 directed: g = x^3+x+1, one input 1 gives remainder x+1
    wr(3'd0, '0); wr(3'd1, 24'h000003); wr(3'd2, '0); wr(3'd3, 24'h000004);
    @(negedge clk); din = 1; din_en = 1; step = 1;
    @(negedge clk); step = 0; din = 0; din_en = 0;
    rd(3'd0, rv);
    check("R3 crc3 remainder", 32'(rv), 32'h3);

    // R5 sweep every mask position, input and gate
    wr(3'd0, 24'hA5C396);
    for (int p = 0; p < W; p++) begin
      wr(3'd3, 24'(1) << p);
      for (int c = 0; c < 4; c++) begin
        @(negedge clk); din = c[0]; din_en = c[1]; #1;
        check("R5 fb_out", 32'(fb_out), 32'(m_fb(24'hA5C396, 24'(1) << p, din & din_en)));
      end
    end
    din = 0; din_en = 0;

    // R6 multi-bit mask uses lowest, empty mask gives 0
    for (int p = 0; p < W - 1; p++) begin
      wr(3'd3, (24'(1) << p) | 24'h800000);
      #1;
      check("R6 lowest bit", 32'(fb_out), 32'(24'hA5C396 >> p) & 32'h1);
    end
    wr(3'd3, '0);
    @(negedge clk); din = 1; din_en = 1; #1;
    check("R6 empty mask", 32'(fb_out), 32'h0);
    din = 0; din_en = 0;

    // R7 zero detect over each single selected bit
    for (int i = 0; i < W; i++) begin
      wr(3'd4, 24'(1) << i);
      wr(3'd0, ~(24'(1) << i)); #1;
      check("R7 clear bit", 32'(zero_flag), 32'h1);
      wr(3'd0, 24'(1) << i); #1;
      check("R7 set bit", 32'(zero_flag), 32'h0);
    end
    wr(3'd4, '0); wr(3'd0, 24'hFFFFFF); #1;
    check("R7 empty select", 32'(zero_flag), 32'h1);

    // R3 random configurations and streams, R7 along the way
    for (int cfg = 0; cfg < 6; cfg++) begin
      logic [W-1:0] fb_t, ff_t, m, sl, s;
      fb_t = W'(nextrand()); ff_t = W'(nextrand());
      m = 24'(1) << (nextrand() % W);
      if (cfg == 5) m = m | 24'h800000;
      sl = W'(nextrand()) & W'(nextrand());
      s = W'(nextrand());
      wr(3'd1, fb_t); wr(3'd2, ff_t); wr(3'd3, m); wr(3'd4, sl); wr(3'd0, s);
      for (int k = 0; k < 300; k++) begin
        logic [31:0] r;
        r = nextrand();
        @(negedge clk);
        din = r[3]; din_en = r[9] | r[10]; step = 1; addr = 3'd0; #1;
        check("R5 fb_out during stream", 32'(fb_out), 32'(m_fb(s, m, din & din_en)));
        s = m_step(s, fb_t, ff_t, m, din & din_en);
        @(negedge clk); step = 0;
        check("R7 flag during stream", 32'(zero_flag), 32'((s & sl) == '0));
        @(negedge clk);
        check("R3 step result", 32'(rd_data), 32'(s));
      end
      din = 0; din_en = 0;
    end

    // R4 hold without step
    wr(3'd0, 24'h5A5A5A);
    repeat (5) @(negedge clk);
    din = 1; din_en = 1;
    repeat (3) @(negedge clk);
    din = 0; din_en = 0;
    rd(3'd0, rv);
    check("R4 hold", 32'(rv), 32'h5A5A5A);

    // R8 local clear keeps configuration
    wr(3'd1, 24'h111111); wr(3'd2, 24'h222222); wr(3'd3, 24'h000008); wr(3'd4, 24'h444444);
    @(negedge clk); loc_clr = 1;
    @(negedge clk); loc_clr = 0;
    rd(3'd0, rv); check("R8 state cleared", 32'(rv), 32'h0);
    rd(3'd1, rv); check("R8 fbt kept", 32'(rv), 32'h111111);
    rd(3'd2, rv); check("R8 fft kept", 32'(rv), 32'h222222);
    rd(3'd3, rv); check("R8 mask kept", 32'(rv), 32'h000008);
    rd(3'd4, rv); check("R8 sel kept", 32'(rv), 32'h444444);

    // R9 load beats step
    @(negedge clk);
    wr_en = 1; addr = 3'd0; wr_data = 24'hC0FFEE; step = 1; din = 1; din_en = 1;
    @(negedge clk);
    wr_en = 0; step = 0; din = 0; din_en = 0;
    rd(3'd0, rv);
    check("R9 load priority", 32'(rv), 32'hC0FFEE);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule